// File: doc/BRIEF.md
# Block Live-In and Producer Detector

This block takes a group of micro-operations presented together in program order, each with a set of source register fields and one destination register field. For every logical register it walks a two-bit state chain from the oldest slot to the youngest. The chain works out whether the group reads that register before anything in the group writes it. Registers that are read first must be looked up in the rename map. Registers that are written first, or never touched, need no lookup.

As an option, selected by a parameter, the block also works out for each source field whether an older slot in the same group wrote that register. When one did, it reports the youngest such slot, so the rename stage can forward the newly allocated name instead of doing a lookup.

The detection logic is combinational. Its results are captured in output registers on the clock edge that samples the valid group.

Top module: `lic_livein_top`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. While `out_valid` is low, `livein_mask`, `prod_hit` and `prod_idx` are all zero.
- R2: While reset is asserted, and right after it, `out_valid`, `livein_mask`, `prod_hit` and `prod_idx` are zero.
- R3: Bit r of `livein_mask` is set exactly when some valid source field names register r and no valid destination in an older slot names r. Slot 0 is the oldest.
- R4: If one slot both reads and writes a register, the read is taken first. That register is live-in unless an older slot wrote it, and the slot's own write never counts as a producer for that slot's own sources.
- R5: A register whose first valid reference in the group is a write is not live-in, even if younger slots read it.
- R6: Source s of slot u occupies flat index i = u*NUM_SRCS+s. Its register is `src_reg[i*4 +: 4]` and its producer index is `prod_idx[i*3 +: 3]`. `prod_hit[i]` is 1 exactly when the source is valid and some older slot has a valid destination equal to its register. `prod_idx` then gives the youngest such slot.
- R7: A source whose valid bit is 0 has no effect on `livein_mask`, and its `prod_hit` and `prod_idx` are 0.
- R8: A destination whose valid bit is 0 has no effect: it neither hides a register from `livein_mask` nor acts as a producer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A group is present on the inputs this cycle |
| src_vld | input | 16 | Valid bit of each source field, flat index u*2+s |
| src_reg | input | 64 | Source register numbers, 4 bits each, flat index u*2+s |
| dst_vld | input | 8 | Valid bit of each slot's destination |
| dst_reg | input | 32 | Destination register numbers, 4 bits per slot |
| out_valid | output | 1 | Registered results are valid |
| livein_mask | output | 16 | One bit per logical register that needs a map lookup |
| prod_hit | output | 16 | Source is supplied by an older slot in the group |
| prod_idx | output | 48 | Producing slot number, 3 bits per source |

## Verification
The checker relies on the register and valid fields being captured on the same edge as `in_valid`. It also relies on the input fields being known values whenever `in_valid` is high. Under those assumptions it can relate each reported producer to the destination fields it saw one cycle earlier.

The bench only drives fully defined fields. It changes them on the falling clock edge, and it compares against a model that scans the group directly rather than through a state chain. The stimulus repeatedly narrows the register numbers to four values, so that collisions, multiple writers and same-slot read-write cases occur often.

// File: rtl/lic_pkg.sv
package lic_pkg;

   // Per-register chain state carried from older slots to younger ones
   typedef enum logic [1:0] {
      CH_IDLE = 2'b00,   // not referenced yet
      CH_DEF  = 2'b01,   // defined inside the group first
      CH_LIVE = 2'b10    // read first: needs a map lookup
   } chain_st_e;

endpackage

// File: rtl/lic_link.sv
module lic_link
   import lic_pkg::*;
(
   input  chain_st_e st_i,
   input  logic      rd,
   input  logic      wr,
   output chain_st_e st_o
);

   // Reads win over writes in the same slot; resolved states are sticky
   always_comb begin
      st_o = st_i;
      if (st_i == CH_IDLE) begin
         if (rd)
            st_o = CH_LIVE;
         else if (wr)
            st_o = CH_DEF;
      end
   end

endmodule

// File: rtl/lic_chain.sv
module lic_chain
   import lic_pkg::*;
#(
   parameter int NUM_UOPS = 8,
   parameter int IW       = 3,
   parameter bit TRACK    = 1'b1
)(
   input  logic [NUM_UOPS-1:0]    rd,
   input  logic [NUM_UOPS-1:0]    wr,
   output logic [NUM_UOPS-1:0]    wv_at,
   output logic [NUM_UOPS*IW-1:0] wi_at,
   output logic                   live
);

   chain_st_e st [NUM_UOPS+1];

   assign st[0] = CH_IDLE;

   for (genvar g = 0; g < NUM_UOPS; g++) begin : g_link
      lic_link u_link (
         .st_i (st[g]),
         .rd   (rd[g]),
         .wr   (wr[g]),
         .st_o (st[g+1])
      );
   end

   assign live = (st[NUM_UOPS] == CH_LIVE);

   // Writer tag seen on entry to each slot: updated on every write
   if (TRACK) begin : g_trk
      for (genvar g = 0; g < NUM_UOPS; g++) begin : g_tag
         if (g == 0) begin : g_first
            assign wv_at[0]    = 1'b0;
            assign wi_at[0+:IW] = '0;
         end else begin : g_rest
            assign wv_at[g] = wv_at[g-1] | wr[g-1];
            assign wi_at[g*IW +: IW] = wr[g-1] ? IW'(g-1)
                                               : wi_at[(g-1)*IW +: IW];
         end
      end
   end else begin : g_notrk
      assign wv_at = '0;
      assign wi_at = '0;
   end

endmodule

// File: rtl/lic_decode.sv
module lic_decode #(
   parameter int NUM_REGS = 16,
   parameter int NUM_SRCS = 2,
   parameter int RW       = 4
)(
   input  logic [NUM_SRCS-1:0]    s_vld,
   input  logic [NUM_SRCS*RW-1:0] s_reg,
   input  logic                   d_vld,
   input  logic [RW-1:0]          d_reg,
   output logic [NUM_REGS-1:0]    rd_hot,
   output logic [NUM_REGS-1:0]    wr_hot
);

   always_comb begin
      rd_hot = '0;
      for (int s = 0; s < NUM_SRCS; s++) begin
         if (s_vld[s])
            rd_hot[s_reg[s*RW +: RW]] = 1'b1;
      end
   end

   always_comb begin
      wr_hot = '0;
      if (d_vld)
         wr_hot[d_reg] = 1'b1;
   end

endmodule

// File: rtl/lic_pick.sv
module lic_pick #(
   parameter int NUM_REGS = 16,
   parameter int RW       = 4,
   parameter int IW       = 3
)(
   input  logic [NUM_REGS-1:0]    wv_col,
   input  logic [NUM_REGS*IW-1:0] wi_col,
   input  logic                   s_vld,
   input  logic [RW-1:0]          s_reg,
   output logic                   hit,
   output logic [IW-1:0]          idx
);

   always_comb begin
      hit = 1'b0;
      idx = '0;
      if (s_vld && wv_col[s_reg]) begin
         hit = 1'b1;
         idx = wi_col[s_reg*IW +: IW];
      end
   end

endmodule

// File: rtl/lic_livein_top.sv
module lic_livein_top #(
   parameter int NUM_UOPS       = 8,
   parameter int NUM_REGS       = 16,
   parameter int NUM_SRCS       = 2,
   parameter bit TRACK_PRODUCER = 1'b1,
   localparam int RW   = $clog2(NUM_REGS),
   localparam int IW   = $clog2(NUM_UOPS),
   localparam int NSRC = NUM_UOPS * NUM_SRCS
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [NSRC-1:0]      src_vld,
   input  logic [NSRC*RW-1:0]   src_reg,
   input  logic [NUM_UOPS-1:0]  dst_vld,
   input  logic [NUM_UOPS*RW-1:0] dst_reg,
   output logic                 out_valid,
   output logic [NUM_REGS-1:0]  livein_mask,
   output logic [NSRC-1:0]      prod_hit,
   output logic [NSRC*IW-1:0]   prod_idx
);

   // Elaboration-time parameter checks
   if (NUM_UOPS < 2) begin : g_bad_uops
      $error("lic_livein_top: NUM_UOPS must be at least 2");
   end
   if (NUM_REGS < 2 || (1 << RW) != NUM_REGS) begin : g_bad_regs
      $error("lic_livein_top: NUM_REGS must be a power of two >= 2");
   end
   if (NUM_SRCS < 1) begin : g_bad_srcs
      $error("lic_livein_top: NUM_SRCS must be at least 1");
   end

   logic [NUM_UOPS-1:0][NUM_REGS-1:0]    rd_u, wr_u, wv_u;
   logic [NUM_UOPS-1:0][NUM_REGS*IW-1:0] wi_u;
   logic [NUM_REGS-1:0][NUM_UOPS-1:0]    rd_c, wr_c, wv_c;
   logic [NUM_REGS-1:0][NUM_UOPS*IW-1:0] wi_c;
   logic [NUM_REGS-1:0]                  live_c;
   logic [NSRC-1:0]                      hit_c;
   logic [NSRC*IW-1:0]                   idx_c;

   // Per-slot decode into one-hot read and write vectors
   for (genvar u = 0; u < NUM_UOPS; u++) begin : g_dec
      lic_decode #(
         .NUM_REGS (NUM_REGS),
         .NUM_SRCS (NUM_SRCS),
         .RW       (RW)
      ) u_dec (
         .s_vld  (src_vld[u*NUM_SRCS +: NUM_SRCS]),
         .s_reg  (src_reg[u*NUM_SRCS*RW +: NUM_SRCS*RW]),
         .d_vld  (dst_vld[u]),
         .d_reg  (dst_reg[u*RW +: RW]),
         .rd_hot (rd_u[u]),
         .wr_hot (wr_u[u])
      );
   end

   // Transpose slot-major to register-major and back
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_xr
      for (genvar u = 0; u < NUM_UOPS; u++) begin : g_xu
         assign rd_c[r][u] = rd_u[u][r];
         assign wr_c[r][u] = wr_u[u][r];
         assign wv_u[u][r] = wv_c[r][u];
         assign wi_u[u][r*IW +: IW] = wi_c[r][u*IW +: IW];
      end
   end

   // One state chain per logical register
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_chain
      lic_chain #(
         .NUM_UOPS (NUM_UOPS),
         .IW       (IW),
         .TRACK    (TRACK_PRODUCER)
      ) u_chain (
         .rd    (rd_c[r]),
         .wr    (wr_c[r]),
         .wv_at (wv_c[r]),
         .wi_at (wi_c[r]),
         .live  (live_c[r])
      );
   end

   // Producer selection for every source field
   for (genvar u = 0; u < NUM_UOPS; u++) begin : g_pu
      for (genvar s = 0; s < NUM_SRCS; s++) begin : g_ps
         localparam int I = u*NUM_SRCS + s;
         lic_pick #(
            .NUM_REGS (NUM_REGS),
            .RW       (RW),
            .IW       (IW)
         ) u_pick (
            .wv_col (wv_u[u]),
            .wi_col (wi_u[u]),
            .s_vld  (src_vld[I]),
            .s_reg  (src_reg[I*RW +: RW]),
            .hit    (hit_c[I]),
            .idx    (idx_c[I*IW +: IW])
         );
      end
   end

   // Result registers: cleared whenever no group was presented
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         livein_mask <= '0;
         prod_hit    <= '0;
         prod_idx    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            livein_mask <= live_c;
            prod_hit    <= hit_c;
            prod_idx    <= idx_c;
         end else begin
            livein_mask <= '0;
            prod_hit    <= '0;
            prod_idx    <= '0;
         end
      end
   end

endmodule

// File: rtl/lic_livein_chk.sv
module lic_livein_chk #(
   parameter int NUM_UOPS       = 8,
   parameter int NUM_REGS       = 16,
   parameter int NUM_SRCS       = 2,
   parameter bit TRACK_PRODUCER = 1'b1,
   localparam int RW   = $clog2(NUM_REGS),
   localparam int IW   = $clog2(NUM_UOPS),
   localparam int NSRC = NUM_UOPS * NUM_SRCS
)(
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [NSRC-1:0]        src_vld,
   input logic [NSRC*RW-1:0]     src_reg,
   input logic [NUM_UOPS-1:0]    dst_vld,
   input logic [NUM_UOPS*RW-1:0] dst_reg,
   input logic                   out_valid,
   input logic [NUM_REGS-1:0]    livein_mask,
   input logic [NSRC-1:0]        prod_hit,
   input logic [NSRC*IW-1:0]     prod_idx
);

   logic [NSRC-1:0]        s_vld_q;
   logic [NSRC*RW-1:0]     s_reg_q;
   logic [NUM_UOPS-1:0]    d_vld_q;
   logic [NUM_UOPS*RW-1:0] d_reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_vld_q <= '0;
         s_reg_q <= '0;
         d_vld_q <= '0;
         d_reg_q <= '0;
      end else begin
         s_vld_q <= src_vld;
         s_reg_q <= src_reg;
         d_vld_q <= dst_vld;
         d_reg_q <= dst_reg;
      end
   end

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R1
   idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R1
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (livein_mask == '0 && prod_hit == '0 && prod_idx == '0));

   for (genvar u = 0; u < NUM_UOPS; u++) begin : g_u
      for (genvar s = 0; s < NUM_SRCS; s++) begin : g_s
         localparam int I = u*NUM_SRCS + s;

         // R6
         prod_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && prod_hit[I]) |-> (prod_idx[I*IW +: IW] < IW'(u)));

         // R6
         prod_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && prod_hit[I]) |->
               (d_vld_q[prod_idx[I*IW +: IW]] &&
                d_reg_q[prod_idx[I*IW +: IW]*RW +: RW] == s_reg_q[I*RW +: RW]));

         // R7
         prod_srcvld_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !s_vld_q[I]) |-> (!prod_hit[I] && prod_idx[I*IW +: IW] == '0));
      end
   end

endmodule

bind lic_livein_top lic_livein_chk #(
   .NUM_UOPS       (NUM_UOPS),
   .NUM_REGS       (NUM_REGS),
   .NUM_SRCS       (NUM_SRCS),
   .TRACK_PRODUCER (TRACK_PRODUCER)
) u_lic_chk (.*);

// File: tb/tb_lic_livein_top.sv
module tb_lic_livein_top;

   localparam int N    = 8;
   localparam int L    = 16;
   localparam int S    = 2;
   localparam int RW   = 4;
   localparam int IW   = 3;
   localparam int NSRC = N*S;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic [NSRC-1:0]     sv = '0;
   logic [NSRC*RW-1:0]  sr = '0;
   logic [N-1:0]        dv = '0;
   logic [N*RW-1:0]     dr = '0;
   logic                out_valid;
   logic [L-1:0]        livein_mask;
   logic [NSRC-1:0]     prod_hit;
   logic [NSRC*IW-1:0]  prod_idx;

   logic [L-1:0]        exp_mask;
   logic [NSRC-1:0]     exp_hit;
   logic [NSRC*IW-1:0]  exp_idx;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;   // 125 MHz

   lic_livein_top dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .src_vld     (sv),
      .src_reg     (sr),
      .dst_vld     (dv),
      .dst_reg     (dr),
      .out_valid   (out_valid),
      .livein_mask (livein_mask),
      .prod_hit    (prod_hit),
      .prod_idx    (prod_idx)
   );

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   // Direct scan model: no state chain
   task automatic model();
      exp_mask = '0;
      exp_hit  = '0;
      exp_idx  = '0;
      for (int u = 0; u < N; u++) begin
         for (int s = 0; s < S; s++) begin
            int i = u*S + s;
            if (sv[i]) begin
               bit older_w = 1'b0;
               for (int k = 0; k < u; k++) begin
                  if (dv[k] && dr[k*RW +: RW] == sr[i*RW +: RW]) begin
                     older_w = 1'b1;
                     exp_hit[i] = 1'b1;
                     exp_idx[i*IW +: IW] = IW'(k);
                  end
               end
               if (!older_w)
                  exp_mask[sr[i*RW +: RW]] = 1'b1;
            end
         end
      end
   endtask

   task automatic clear_in();
      sv = '0; sr = '0; dv = '0; dr = '0;
   endtask

   task automatic set_src(int u, int s, int r);
      sv[u*S+s] = 1'b1;
      sr[(u*S+s)*RW +: RW] = RW'(r);
   endtask

   task automatic set_dst(int u, int r);
      dv[u] = 1'b1;
      dr[u*RW +: RW] = RW'(r);
   endtask

   // Present the current fields for one cycle, check at next falling edge
   task automatic apply(string req);
      in_valid = 1'b1;
      model();
      @(negedge clk);
      chk({req, " valid"}, 64'(out_valid), 64'(1));
      chk({req, " mask"},  64'(livein_mask), 64'(exp_mask));
      chk({req, " hit"},   64'(prod_hit), 64'(exp_hit));
      chk({req, " idx"},   64'(prod_idx), 64'(exp_idx));
   endtask

   initial begin
      #(8*200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2 valid", 64'(out_valid), 64'(0));
      chk("R2 mask",  64'(livein_mask), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 after release", 64'({out_valid, livein_mask, prod_hit}), 64'(0));

      // R7 R8: all fields carry registers but every valid bit is 0
      clear_in();
      for (int u = 0; u < N; u++) begin
         dr[u*RW +: RW] = RW'(u);
         for (int s = 0; s < S; s++) sr[(u*S+s)*RW +: RW] = RW'(u+s+1);
      end
      apply("R7 R8 all invalid");

      // R4: slot 0 reads and writes r5; slot 1 reads r5
      clear_in();
      set_src(0, 0, 5); set_dst(0, 5); set_src(1, 1, 5);
      apply("R4 same slot read-write");
      chk("R4 mask bit5", 64'(livein_mask[5]), 64'(1));
      chk("R4 slot0 no self hit", 64'(prod_hit[0]), 64'(0));

      // R5: written first, read later
      clear_in();
      set_dst(0, 3); set_src(3, 0, 3); set_src(5, 1, 3);
      apply("R5 written first");
      chk("R5 mask bit3", 64'(livein_mask[3]), 64'(0));

      // R6: youngest older writer chosen
      clear_in();
      set_dst(1, 7); set_dst(4, 7); set_src(3, 0, 7); set_src(6, 1, 7);
      set_src(7, 0, 9); set_dst(7, 9);
      apply("R6 multiple writers");
      chk("R6 slot6 idx", 64'(prod_idx[13*IW +: IW]), 64'(4));
      chk("R6 slot3 idx", 64'(prod_idx[6*IW +: IW]),  64'(1));

      // R8: invalid destination does not hide a read
      clear_in();
      dr[0 +: RW] = RW'(2); set_src(2, 0, 2);
      apply("R8 invalid dst");
      chk("R8 mask bit2", 64'(livein_mask[2]), 64'(1));

      // R3: read of r15 in youngest slot, r0 in oldest
      clear_in();
      set_src(0, 0, 0); set_src(7, 1, 15); set_dst(3, 0);
      apply("R3 edge registers");

      // R1: idle cycle clears outputs
      in_valid = 1'b0;
      @(negedge clk);
      chk("R1 idle valid", 64'(out_valid), 64'(0));
      chk("R1 idle zero", 64'({livein_mask, prod_hit}), 64'(0));

      // R3 R6: back-to-back pseudo-random groups, often narrowed to 4 regs
      for (int t = 0; t < 3000; t++) begin
         logic [31:0] a = rnd();
         logic [31:0] b = rnd();
         logic [31:0] c = rnd();
         logic [3:0]  msk = (t % 3 == 0) ? 4'hF : 4'h3;
         sv = b[NSRC-1:0] | c[NSRC-1:0];
         dv = a[N-1:0] | c[N+7:N];
         for (int i = 0; i < NSRC; i++) sr[i*RW +: RW] = rnd()[3:0] & msk;
         for (int u = 0; u < N; u++) dr[u*RW +: RW] = rnd()[3:0] & msk;
         apply("R3 R6 random");
      end

      in_valid = 1'b0;
      @(negedge clk);
      chk("R1 final idle", 64'(out_valid), 64'(0));
      report();
   end

endmodule